// File: doc/BRIEF.md
# Write-Address Handshake Rule Monitor

This block sits beside one write-address channel of a valid/ready bus and watches it without driving it. It checks that the sender keeps its request up once it has raised it, that no part of the request changes while the request waits for acceptance, and that the receiver accepts within a programmable number of cycles. Each broken rule leaves a sticky flag set until the next reset, so a system can read or probe the flags long after the event.

Address, ID, length, size, burst, lock, cache and protection fields are each checked on their own, so a flag names the field that moved. The ID and address widths are parameters. The other field widths are fixed: length 4 bits, size 3, burst 2, lock 2, cache 4, protection 3. The slow-acceptance rule is only a recommendation. It raises a warning that is kept apart from the combined error, and it needs two enables that are both set.

Top module: `hs_rule_monitor`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is sampled high, every flag clears and all bus activity is ignored. On the first cycle after reset no field comparison takes place, whatever the payload does.
- R2: A cycle is stalled when `a_valid` is 1 and `a_ready` is 0. If the previous cycle was stalled and `a_valid` is still 1, any field that differs from its value in the first cycle of that stall sets its bit of `err_field` at the next edge. Bit 0 is address, 1 ID, 2 length, 3 size, 4 burst, 5 lock, 6 cache and 7 protection.
- R3: The comparison window ends as soon as a cycle is no longer stalled. A payload change in the cycle where `a_ready` rises after a stall is still checked. A change in the cycle after an accepted transfer, or after a cycle with `a_valid` low, is not an error.
- R4: If the previous cycle was stalled and `a_valid` is now 0, `err_vdrop` is set at the next edge.
- R5: A stalled cycle preceded by at least `wait_limit` consecutive stalled cycles sets `warn_wait` at the next edge. Acceptance in the cycle after exactly `wait_limit` stalled cycles causes no warning, and `wait_limit` = 0 warns on the first stalled cycle.
- R6: `warn_wait` can be set only when `chk_rec_en` and `chk_wait_en` are both 1.
- R7: The stall-cycle count clears whenever `a_valid` is 0 or `a_ready` is 1. A request that is withdrawn before acceptance therefore never produces a wait warning, and a new stall counts from zero.
- R8: With `chk_err_en` at 0, the R2 and R4 rules set no flags.
- R9: All flags are sticky until reset. `err_any` is the OR of `err_field` and `err_vdrop`, updated on the same edge as they are. `warn_wait` is not part of `err_any`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chk_err_en | input | 1 | Enables the error rules (field stability, valid withdrawal) |
| chk_rec_en | input | 1 | Global enable for recommendation rules |
| chk_wait_en | input | 1 | Enable for the acceptance-wait warning |
| wait_limit | input | CNT_W | Number of stalled cycles allowed before warning |
| a_valid | input | 1 | Channel request valid |
| a_ready | input | 1 | Channel request accepted |
| a_addr | input | ADDR_W | Address field |
| a_id | input | ID_W | Transaction ID field |
| a_len | input | 4 | Burst length field |
| a_size | input | 3 | Transfer size field |
| a_burst | input | 2 | Burst type field |
| a_lock | input | 2 | Lock type field |
| a_cache | input | 4 | Cache attribute field |
| a_prot | input | 3 | Protection field |
| err_field | output | 8 | Sticky per-field stability error, bit order as in R2 |
| err_vdrop | output | 1 | Sticky valid-withdrawn error |
| err_any | output | 1 | OR of all error flags |
| warn_wait | output | 1 | Sticky slow-acceptance warning |

## Verification
The bench walks every field through a one-bit change inside a stall, so a design that wires a field to the wrong flag bit, or leaves a field out, shows the wrong bit pattern. It targets the window edges: a change on the cycle `a_ready` rises, which a design that closes the window one cycle early would miss, and a change right after acceptance or after reset, which a design that closes it late would flag falsely. For the wait timer it stalls for exactly `wait_limit` cycles and then for one more. An off-by-one counter warns too early or too late there. A counter that does not clear on withdrawal warns on the second short stall. Random segments with random enables and limits check every cycle against a bench model.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  localparam int NFLD    = 8;
  localparam int LEN_W   = 4;
  localparam int SIZE_W  = 3;
  localparam int BURST_W = 2;
  localparam int LOCK_W  = 2;
  localparam int CACHE_W = 4;
  localparam int PROT_W  = 3;

  // Width of payload field idx; order: addr, id, len, size, burst, lock, cache, prot
  function automatic int fld_width(int idx, int aw, int iw);
    case (idx)
      0:       return aw;
      1:       return iw;
      2:       return LEN_W;
      3:       return SIZE_W;
      4:       return BURST_W;
      5:       return LOCK_W;
      6:       return CACHE_W;
      7:       return PROT_W;
      default: return 0;
    endcase
  endfunction

  // Low bit of field idx inside the packed payload
  function automatic int fld_base(int idx, int aw, int iw);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += fld_width(k, aw, iw);
    return acc;
  endfunction
endpackage

// File: rtl/hsm_field_hold.sv
module hsm_field_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chk_en,
  input  logic         stall_q,
  input  logic         valid,
  input  logic [W-1:0] fld,
  output logic         hit,
  output logic         err
);
  logic [W-1:0] snap;

  // Snapshot follows the field until a stall is under way, then holds
  always_ff @(posedge clk) begin
    if (rst)          snap <= '0;
    else if (!stall_q) snap <= fld;
  end

  assign hit = chk_en && stall_q && valid && (fld != snap);

  always_ff @(posedge clk) begin
    if (rst)      err <= 1'b0;
    else if (hit) err <= 1'b1;
  end
endmodule

// File: rtl/hsm_stall_track.sv
module hsm_stall_track (
  input  logic clk,
  input  logic rst,
  input  logic chk_en,
  input  logic valid,
  input  logic ready,
  output logic stall_q,
  output logic hit,
  output logic vdrop
);
  always_ff @(posedge clk) begin
    if (rst) stall_q <= 1'b0;
    else     stall_q <= valid && !ready;
  end

  assign hit = chk_en && stall_q && !valid;

  always_ff @(posedge clk) begin
    if (rst)      vdrop <= 1'b0;
    else if (hit) vdrop <= 1'b1;
  end
endmodule

// File: rtl/hsm_wait_timer.sv
module hsm_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate,
  input  logic             valid,
  input  logic             ready,
  input  logic [CNT_W-1:0] limit,
  output logic             warn
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             hit;

  always_ff @(posedge clk) begin
    if (rst || !valid || ready) cnt <= '0;
    else if (cnt != CMAX)       cnt <= cnt + 1'b1;
  end

  assign hit = gate && valid && !ready && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst)      warn <= 1'b0;
    else if (hit) warn <= 1'b1;
  end
endmodule

// File: rtl/hs_rule_monitor.sv
module hs_rule_monitor #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int CNT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       chk_err_en,
  input  logic                       chk_rec_en,
  input  logic                       chk_wait_en,
  input  logic [CNT_W-1:0]           wait_limit,
  input  logic                       a_valid,
  input  logic                       a_ready,
  input  logic [ADDR_W-1:0]          a_addr,
  input  logic [ID_W-1:0]            a_id,
  input  logic [hsm_pkg::LEN_W-1:0]  a_len,
  input  logic [hsm_pkg::SIZE_W-1:0] a_size,
  input  logic [hsm_pkg::BURST_W-1:0] a_burst,
  input  logic [hsm_pkg::LOCK_W-1:0] a_lock,
  input  logic [hsm_pkg::CACHE_W-1:0] a_cache,
  input  logic [hsm_pkg::PROT_W-1:0] a_prot,
  output logic [hsm_pkg::NFLD-1:0]   err_field,
  output logic                       err_vdrop,
  output logic                       err_any,
  output logic                       warn_wait
);
  import hsm_pkg::*;

  localparam int PAY_W = fld_base(NFLD, ADDR_W, ID_W);

  logic [PAY_W-1:0] pay;
  logic [NFLD-1:0]  fld_hit;
  logic             stall_q;
  logic             drop_hit;

  assign pay = {a_prot, a_cache, a_lock, a_burst, a_size, a_len, a_id, a_addr};

  hsm_stall_track u_stall (
    .clk    (clk),
    .rst    (rst),
    .chk_en (chk_err_en),
    .valid  (a_valid),
    .ready  (a_ready),
    .stall_q(stall_q),
    .hit    (drop_hit),
    .vdrop  (err_vdrop)
  );

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    localparam int FW = fld_width(g, ADDR_W, ID_W);
    localparam int FB = fld_base(g, ADDR_W, ID_W);
    hsm_field_hold #(.W(FW)) u_hold (
      .clk    (clk),
      .rst    (rst),
      .chk_en (chk_err_en),
      .stall_q(stall_q),
      .valid  (a_valid),
      .fld    (pay[FB +: FW]),
      .hit    (fld_hit[g]),
      .err    (err_field[g])
    );
  end

  hsm_wait_timer #(.CNT_W(CNT_W)) u_wait (
    .clk  (clk),
    .rst  (rst),
    .gate (chk_rec_en && chk_wait_en),
    .valid(a_valid),
    .ready(a_ready),
    .limit(wait_limit),
    .warn (warn_wait)
  );

  // Combined error kept as its own register, set on the same edge as the flags
  always_ff @(posedge clk) begin
    if (rst)                        err_any <= 1'b0;
    else if ((|fld_hit) || drop_hit) err_any <= 1'b1;
  end
endmodule

// File: rtl/hsm_rule_checker.sv
module hsm_rule_checker #(
  parameter int NFLD = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            a_valid,
  input logic            a_ready,
  input logic            chk_err_en,
  input logic            chk_rec_en,
  input logic            chk_wait_en,
  input logic [NFLD-1:0] err_field,
  input logic            err_vdrop,
  input logic            err_any,
  input logic            warn_wait
);
  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((($past(err_field) & ~err_field) == '0) &&
                     (!$past(err_vdrop) || err_vdrop) &&
                     (!$past(warn_wait) || warn_wait)));

  assert_any_or_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (err_any == ((|err_field) || err_vdrop)));

  assert_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (a_valid && !a_ready) ##1 (!a_valid && chk_err_en) |=> err_vdrop);

  assert_field_cause_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (err_field != $past(err_field))) |-> $past(a_valid && chk_err_en));

  assert_warn_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(warn_wait)) |->
      $past(chk_rec_en && chk_wait_en && a_valid && !a_ready));
endmodule

bind hs_rule_monitor hsm_rule_checker #(.NFLD(hsm_pkg::NFLD)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .a_valid    (a_valid),
  .a_ready    (a_ready),
  .chk_err_en (chk_err_en),
  .chk_rec_en (chk_rec_en),
  .chk_wait_en(chk_wait_en),
  .err_field  (err_field),
  .err_vdrop  (err_vdrop),
  .err_any    (err_any),
  .warn_wait  (warn_wait)
);

// File: tb/hs_rule_monitor_bench.sv
`timescale 1ns/1ps
module hs_rule_monitor_bench;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          en_err = 1'b1, en_rec = 1'b1, en_wait = 1'b1;
  logic [CW-1:0] lim = 8'd3;
  logic          v = 1'b0, r = 1'b0;
  logic [31:0]   fv [8];
  int            fw [8] = '{AW, IW, 4, 3, 2, 2, 4, 3};

  logic [7:0] err_field;
  logic       err_vdrop, err_any, warn_wait;

  hs_rule_monitor #(.ADDR_W(AW), .ID_W(IW), .CNT_W(CW)) u_hs_rule_monitor (
    .clk(clk), .rst(rst), .chk_err_en(en_err), .chk_rec_en(en_rec),
    .chk_wait_en(en_wait), .wait_limit(lim), .a_valid(v), .a_ready(r),
    .a_addr(fv[0][AW-1:0]), .a_id(fv[1][IW-1:0]), .a_len(fv[2][3:0]),
    .a_size(fv[3][2:0]), .a_burst(fv[4][1:0]), .a_lock(fv[5][1:0]),
    .a_cache(fv[6][3:0]), .a_prot(fv[7][2:0]),
    .err_field(err_field), .err_vdrop(err_vdrop), .err_any(err_any),
    .warn_wait(warn_wait));

  // Bench model state
  logic [31:0] ms [8];
  logic [7:0]  me;
  logic        mv, mw, mstall;
  int          mcnt;
  int          nvec = 0, nbad = 0;

  function automatic logic [31:0] fmask(int i);
    return 32'((64'd1 << fw[i]) - 64'd1);
  endfunction

  task automatic model_edge();
    if (rst) begin
      me = '0; mv = 1'b0; mw = 1'b0; mstall = 1'b0; mcnt = 0;
      for (int i = 0; i < 8; i++) ms[i] = '0;
    end else begin
      if (mstall && v && en_err)
        for (int i = 0; i < 8; i++)
          if ((fv[i] & fmask(i)) != ms[i]) me[i] = 1'b1;
      if (mstall && !v && en_err) mv = 1'b1;
      if (en_rec && en_wait && v && !r && mcnt >= int'(lim)) mw = 1'b1;
      if (!v || r) mcnt = 0;
      else if (mcnt != 255) mcnt++;
      if (!mstall) for (int i = 0; i < 8; i++) ms[i] = fv[i] & fmask(i);
      mstall = v && !r;
    end
  endtask

  task automatic cmp(string ctx);
    logic bad;
    bad = 1'b0;
    nvec++;
    if (err_field !== me) begin
      bad = 1'b1;
      $display("FAIL R2 [%s] err_field act=%b exp=%b", ctx, err_field, me);
    end
    if (err_vdrop !== mv) begin
      bad = 1'b1;
      $display("FAIL R4 [%s] err_vdrop act=%b exp=%b", ctx, err_vdrop, mv);
    end
    if (warn_wait !== mw) begin
      bad = 1'b1;
      $display("FAIL R5 [%s] warn_wait act=%b exp=%b", ctx, warn_wait, mw);
    end
    if (err_any !== ((|me) || mv)) begin
      bad = 1'b1;
      $display("FAIL R9 [%s] err_any act=%b exp=%b", ctx, err_any, (|me) || mv);
    end
    if (bad) nbad++;
  endtask

  task automatic cyc(string ctx);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cmp(ctx);
  endtask

  task automatic do_reset();
    rst = 1'b1; v = 1'b0; r = 1'b0;
    cyc("R1"); cyc("R1");
    rst = 1'b0;
  endtask

  task automatic stall_n(int n, string ctx);
    v = 1'b1; r = 1'b0;
    for (int k = 0; k < n; k++) cyc(ctx);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    for (int i = 0; i < 8; i++) fv[i] = 32'h0;

    // R1: stalled request during reset, payload differs right after
    rst = 1'b1; v = 1'b1; r = 1'b0;
    cyc("R1"); cyc("R1");
    rst = 1'b0; fv[0] ^= 32'h1;
    cyc("R1");
    fv[0] ^= 32'h1; v = 1'b0;
    cyc("R1");

    // R2: each field moved by one bit inside a stall
    for (int i = 0; i < 8; i++) begin
      do_reset();
      stall_n(1, "R2");
      fv[i] ^= 32'h1;
      cyc("R2");
      r = 1'b1; cyc("R2");
    end

    // R3: change on the rising-ready cycle is checked
    do_reset();
    stall_n(1, "R3");
    fv[2] ^= 32'h1; r = 1'b1;
    cyc("R3");
    // R3: change right after acceptance is not checked
    do_reset();
    v = 1'b1; r = 1'b1; cyc("R3");
    fv[3] ^= 32'h1; r = 1'b0; cyc("R3");
    r = 1'b1; cyc("R3");
    // R3: change after an idle cycle is not checked
    do_reset();
    v = 1'b0; cyc("R3");
    fv[6] ^= 32'h1; v = 1'b1; r = 1'b0; cyc("R3");
    r = 1'b1; cyc("R3");

    // R4: request withdrawn while stalled
    do_reset();
    stall_n(2, "R4");
    v = 1'b0; cyc("R4"); cyc("R4");

    // R8: error rules disabled
    do_reset();
    en_err = 1'b0;
    stall_n(1, "R8");
    fv[1] ^= 32'h1; cyc("R8");
    v = 1'b0; cyc("R8"); cyc("R8");
    en_err = 1'b1;

    // R5: exactly lim stalls then accept, then lim+1 stalls, then lim=0
    lim = 8'd3;
    do_reset();
    stall_n(3, "R5");
    r = 1'b1; cyc("R5");
    v = 1'b0; r = 1'b0; cyc("R5");
    do_reset();
    stall_n(4, "R5");
    r = 1'b1; cyc("R5");
    lim = 8'd0;
    do_reset();
    stall_n(1, "R5");
    r = 1'b1; cyc("R5");

    // R6: each enable alone blocks the warning
    lim = 8'd1;
    do_reset();
    en_rec = 1'b0;
    stall_n(4, "R6");
    r = 1'b1; cyc("R6");
    en_rec = 1'b1; en_wait = 1'b0;
    do_reset();
    stall_n(4, "R6");
    r = 1'b1; cyc("R6");
    en_wait = 1'b1;

    // R7: withdrawal clears the count; a new stall starts at zero
    lim = 8'd3;
    do_reset();
    stall_n(3, "R7");
    v = 1'b0; cyc("R7");
    stall_n(3, "R7");
    r = 1'b1; cyc("R7");
    stall_n(2, "R7");
    r = 1'b1; cyc("R7");
    v = 1'b0; r = 1'b0; cyc("R7");

    // Random segments
    for (int s = 0; s < 60; s++) begin
      do_reset();
      en_err  = ($urandom % 5) != 0;
      en_rec  = ($urandom % 4) != 0;
      en_wait = ($urandom % 4) != 0;
      lim     = CW'($urandom % 6);
      for (int c = 0; c < 40; c++) begin
        if (v && !r) begin
          v = ($urandom % 12) != 0;
          if (($urandom % 10) == 0) fv[$urandom % 8] ^= 32'h1;
        end else begin
          v = ($urandom % 3) != 0;
          if (($urandom % 2) == 0)
            for (int i = 0; i < 8; i++) fv[i] = $urandom & fmask(i);
        end
        r = ($urandom % 3) == 0;
        cyc("random");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule